// File: doc/BRIEF.md
# Pipeline Hazard Detection and Forwarding

This block is the hazard controller for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It looks at the source registers of the instructions in decode and execute, and at the destination, write-enable and load information of the older instructions further down. From these it picks, for each ALU operand, whether the value comes from the register file, from the memory-stage result or from the writeback-stage result. It detects a load whose result is needed by the very next instruction. It also reacts to a taken branch or jump resolved in execute.

The outputs are all combinational from the current pipeline-register contents. The stall output holds the PC and the fetch/decode register. The bubble output turns the instruction entering execute into a nop. The flush output cancels the two younger instructions after a taken redirect. The datapath acts on these signals within the same cycle. A decode-stage read needs no forwarding from writeback, because the register file writes early and reads late in the cycle.

Top module: `pipeline_hazard_ctl`

## Requirements
- R1: When the memory-stage instruction writes a nonzero register equal to an execute-stage source, that operand's select is 2'b10 (memory-stage result).
- R2: When only the writeback-stage instruction writes a nonzero register equal to an execute-stage source, that operand's select is 2'b01 (writeback result, including load data).
- R3: When both the memory and the writeback stage match the same source, the memory stage wins (2'b10). Each operand is resolved on its own.
- R4: A source or destination of register 0 is never forwarded, and the select stays 2'b00 (register file).
- R5: A stage whose write enable is low is never a forwarding source. With no matching writer the select is 2'b00.
- R6: A load in execute with write enable and nonzero destination equal to a used decode source raises stall and bubble together for that cycle.
- R7: A decode source whose use flag is low never causes a stall. A store marks its rs2 as used, so it stalls behind a load to that register.
- R8: A non-load execute instruction, or a load to register 0, never causes a stall.
- R9: A taken branch or jump in execute raises flush.
- R10: When a redirect and a load-use hazard coincide, flush is raised and stall and bubble stay low.
- R11: All outputs follow their inputs within the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used only for sampling checks |
| rst_ni | input | 1 | Active-low asynchronous reset, used only for checks |
| id_rs1_i | input | 5 | Decode source 1 register |
| id_rs2_i | input | 5 | Decode source 2 register |
| id_use_rs1_i | input | 1 | Decode instruction reads source 1 |
| id_use_rs2_i | input | 1 | Decode instruction reads source 2 (set for stores) |
| ex_rs1_i | input | 5 | Execute source 1 register |
| ex_rs2_i | input | 5 | Execute source 2 register |
| ex_rd_i | input | 5 | Execute destination register |
| ex_we_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| ex_redirect_i | input | 1 | Taken branch or jump resolved in execute |
| mem_rd_i | input | 5 | Memory-stage destination register |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| wb_rd_i | input | 5 | Writeback destination register |
| wb_we_i | input | 1 | Writeback instruction writes a register |
| fwd_a_o | output | 2 | Operand A select: 00 register file, 01 writeback, 10 memory stage |
| fwd_b_o | output | 2 | Operand B select, same encoding |
| stall_o | output | 1 | Hold PC and fetch/decode register |
| bubble_o | output | 1 | Turn the instruction entering execute into a nop |
| flush_o | output | 1 | Cancel the two younger instructions |

## Verification
A taken redirect in execute and a load-use hazard between execute and decode can occur in the same cycle. In that case the flush must win and the stall and bubble must be suppressed. The bench sets a load in execute whose destination matches a used decode source and raises the redirect input in the same vector. It then checks that flush is high while stall and bubble are low. The other overlap is memory-stage and writeback-stage forwarding of one register. The bench places the same destination in both stages and checks that the memory-stage select is chosen, including a case where the two operands resolve to different stages.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NSRC = 2;
endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output logic [1:0]    sel_o
);
  import hz_pkg::*;

  logic mem_hit, wb_hit;

  // register 0 is hardwired, never a forwarding source
  assign mem_hit = mem_we_i && (mem_rd_i != '0) && (mem_rd_i == src_i);
  assign wb_hit  = wb_we_i  && (wb_rd_i  != '0) && (wb_rd_i  == src_i);

  always_comb begin
    if (mem_hit)     sel_o = FWD_MEM;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] id_src_i,
  input  logic [NSRC-1:0]         id_use_i,
  input  logic [AW-1:0]           ex_rd_i,
  input  logic                    ex_we_i,
  input  logic                    ex_load_i,
  output logic                    hit_o
);
  logic            ld_valid;
  logic [NSRC-1:0] src_hit;

  assign ld_valid = ex_load_i && ex_we_i && (ex_rd_i != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_hit[g] = id_use_i[g] && (id_src_i[g] == ex_rd_i);
  end

  assign hit_o = ld_valid && (|src_hit);
endmodule

// File: rtl/hz_ctl.sv
module hz_ctl (
  input  logic load_use_i,
  input  logic redirect_i,
  output logic stall_o,
  output logic bubble_o,
  output logic flush_o
);
  // redirect cancels the dependent instruction, so no stall is needed
  assign flush_o  = redirect_i;
  assign stall_o  = load_use_i && !redirect_i;
  assign bubble_o = load_use_i && !redirect_i;
endmodule

// File: rtl/pipeline_hazard_ctl.sv
module pipeline_hazard_ctl #(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic          id_use_rs1_i,
  input  logic          id_use_rs2_i,
  input  logic [AW-1:0] ex_rs1_i,
  input  logic [AW-1:0] ex_rs2_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  input  logic          ex_redirect_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          stall_o,
  output logic          bubble_o,
  output logic          flush_o
);
  import hz_pkg::*;

  logic [NSRC-1:0][AW-1:0] ex_src, id_src;
  logic [NSRC-1:0][1:0]    sel;
  logic [NSRC-1:0]         id_use;
  logic                    load_use;

  assign ex_src = {ex_rs2_i, ex_rs1_i};
  assign id_src = {id_rs2_i, id_rs1_i};
  assign id_use = {id_use_rs2_i, id_use_rs1_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_fwd
    hz_fwd_unit #(.AW(AW)) i_fwd (
      .src_i    (ex_src[g]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (sel[g])
    );
  end

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];

  hz_load_use #(.AW(AW), .NSRC(NSRC)) i_lu (
    .id_src_i  (id_src),
    .id_use_i  (id_use),
    .ex_rd_i   (ex_rd_i),
    .ex_we_i   (ex_we_i),
    .ex_load_i (ex_load_i),
    .hit_o     (load_use)
  );

  hz_ctl i_ctl (
    .load_use_i (load_use),
    .redirect_i (ex_redirect_i),
    .stall_o    (stall_o),
    .bubble_o   (bubble_o),
    .flush_o    (flush_o)
  );
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int unsigned AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] id_rs1_i,
  input logic          id_use_rs1_i,
  input logic [AW-1:0] ex_rs1_i,
  input logic [AW-1:0] ex_rs2_i,
  input logic [AW-1:0] ex_rd_i,
  input logic          ex_we_i,
  input logic          ex_load_i,
  input logic          ex_redirect_i,
  input logic [AW-1:0] mem_rd_i,
  input logic          mem_we_i,
  input logic          wb_we_i,
  input logic [1:0]    fwd_a_o,
  input logic [1:0]    fwd_b_o,
  input logic          stall_o,
  input logic          bubble_o,
  input logic          flush_o
);
  a_r3_mem_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && mem_rd_i != '0 && mem_rd_i == ex_rs1_i) |-> fwd_a_o == 2'b10);

  a_r4_no_x0_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs1_i == '0) |-> fwd_a_o == 2'b00);

  a_r5_no_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_i && !wb_we_i) |-> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

  a_r6_load_use: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_load_i && ex_we_i && ex_rd_i != '0 && id_use_rs1_i &&
     id_rs1_i == ex_rd_i && !ex_redirect_i) |-> (stall_o && bubble_o));

  a_r8_no_load_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_load_i |-> !stall_o);

  a_r9_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_redirect_i |-> flush_o);

  a_r10_flush_over_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (!stall_o && !bubble_o));
endmodule

bind pipeline_hazard_ctl hz_checker #(.AW(AW)) i_hz_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .id_rs1_i      (id_rs1_i),
  .id_use_rs1_i  (id_use_rs1_i),
  .ex_rs1_i      (ex_rs1_i),
  .ex_rs2_i      (ex_rs2_i),
  .ex_rd_i       (ex_rd_i),
  .ex_we_i       (ex_we_i),
  .ex_load_i     (ex_load_i),
  .ex_redirect_i (ex_redirect_i),
  .mem_rd_i      (mem_rd_i),
  .mem_we_i      (mem_we_i),
  .wb_we_i       (wb_we_i),
  .fwd_a_o       (fwd_a_o),
  .fwd_b_o       (fwd_b_o),
  .stall_o       (stall_o),
  .bubble_o      (bubble_o),
  .flush_o       (flush_o)
);

// File: tb/test_pipeline_hazard_ctl.sv
module test_pipeline_hazard_ctl;
  typedef struct packed {
    logic [31:0] tag;
    logic [4:0]  id_rs1, id_rs2;
    logic        u1, u2;
    logic [4:0]  ex_rs1, ex_rs2, ex_rd;
    logic        ex_we, ex_ld;
    logic [4:0]  mem_rd;
    logic        mem_we;
    logic [4:0]  wb_rd;
    logic        wb_we, redir;
    logic [1:0]  e_fa, e_fb;
    logic        e_stall, e_bub, e_flush;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{"R1",  0, 0,0,0,  5, 6, 0,0,0,  5,1,  0,0, 0, 2,0, 0,0,0},
    '{"R2",  0, 0,0,0,  3, 7, 0,0,0,  0,0,  7,1, 0, 0,1, 0,0,0},
    '{"R3",  0, 0,0,0,  9, 9, 0,0,0,  9,1,  9,1, 0, 2,2, 0,0,0},
    '{"R3",  0, 0,0,0,  4, 8, 0,0,0,  4,1,  8,1, 0, 2,1, 0,0,0},
    '{"R4",  0, 0,0,0,  0, 0, 0,0,0,  0,1,  0,1, 0, 0,0, 0,0,0},
    '{"R5",  0, 0,0,0, 12,12, 0,0,0, 12,0, 12,0, 0, 0,0, 0,0,0},
    '{"R6", 10, 0,1,0,  0, 0,10,1,1,  0,0,  0,0, 0, 0,0, 1,1,0},
    '{"R7",  2,11,1,1,  0, 0,11,1,1,  0,0,  0,0, 0, 0,0, 1,1,0},
    '{"R7",  2,11,1,0,  0, 0,11,1,1,  0,0,  0,0, 0, 0,0, 0,0,0},
    '{"R8", 13, 0,1,0,  0, 0,13,1,0,  0,0,  0,0, 0, 0,0, 0,0,0},
    '{"R8",  0, 0,1,1,  0, 0, 0,1,1,  0,0,  0,0, 0, 0,0, 0,0,0},
    '{"R9",  0, 0,0,0,  0, 0, 0,0,0,  0,0,  0,0, 1, 0,0, 0,0,1},
    '{"R10",10, 0,1,0,  0, 0,10,1,1,  0,0,  0,0, 1, 0,0, 0,0,1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
  logic [4:0] mem_rd = '0, wb_rd = '0;
  logic       u1 = 0, u2 = 0, ex_we = 0, ex_ld = 0, redir = 0, mem_we = 0, wb_we = 0;
  logic [1:0] fa, fb;
  logic       stall, bub, flush;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pipeline_hazard_ctl i_pipeline_hazard_ctl (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
    .id_use_rs1_i(u1), .id_use_rs2_i(u2),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd),
    .ex_we_i(ex_we), .ex_load_i(ex_ld), .ex_redirect_i(redir),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .fwd_a_o(fa), .fwd_b_o(fb),
    .stall_o(stall), .bubble_o(bub), .flush_o(flush)
  );

  task automatic drive(input vec_t v);
    id_rs1 = v.id_rs1; id_rs2 = v.id_rs2; u1 = v.u1; u2 = v.u2;
    ex_rs1 = v.ex_rs1; ex_rs2 = v.ex_rs2; ex_rd = v.ex_rd;
    ex_we = v.ex_we; ex_ld = v.ex_ld; redir = v.redir;
    mem_rd = v.mem_rd; mem_we = v.mem_we; wb_rd = v.wb_rd; wb_we = v.wb_we;
  endtask

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {fa, fb, stall, bub, flush};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: fa,fb,stall,bubble,flush actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    check("R5 reset state", 7'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #2;
      check($sformatf("%s vec %0d", VECS[i].tag, i),
            {VECS[i].e_fa, VECS[i].e_fb, VECS[i].e_stall, VECS[i].e_bub, VECS[i].e_flush});
    end

    // R1 boundary: highest register number
    @(negedge clk);
    v = '0; v.ex_rs2 = 31; v.mem_rd = 31; v.mem_we = 1;
    drive(v); #2;
    check("R1 reg 31", 7'b00_10_000);

    // R4: register-0 writer in memory stage with nonzero-writer in writeback
    @(negedge clk);
    v = '0; v.ex_rs1 = 0; v.mem_rd = 0; v.mem_we = 1; v.wb_rd = 0; v.wb_we = 1;
    v.ex_rs2 = 3; v.wb_rd = 3;
    drive(v); #2;
    check("R4 x0 vs wb", 7'b00_01_000);

    // R11: inputs change mid-cycle, outputs follow before any edge
    @(posedge clk); #1;
    v = '0; v.id_rs2 = 20; v.u2 = 1; v.ex_rd = 20; v.ex_we = 1; v.ex_ld = 1;
    drive(v); #1;
    check("R11 same-cycle stall", 7'b00_00_110);
    v.redir = 1;
    drive(v); #1;
    check("R11 same-cycle flush", 7'b00_00_001);

    // R7: store rs2 used but load writes disabled -> no stall
    @(negedge clk);
    v = '0; v.id_rs2 = 20; v.u2 = 1; v.ex_rd = 20; v.ex_we = 0; v.ex_ld = 1;
    drive(v); #2;
    check("R7 load without write", 7'b0);

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule